// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits on the controller side of an SDRAM interface, between the command arbiter and the command pins. It keeps count of the auto-refresh commands the memory is owed at the required average rate, and issues them when the arbiter offers a slot or when the backlog reaches its limit. It also takes the device into and out of self-refresh and precharge power-down by driving the clock-enable line together with the command lines. All interval arithmetic is done in clock cycles derived from a clock-period parameter.

The arbiter makes requests with level inputs: refresh now, enter self-refresh, enter power-down, wake. It reports through `all_idle` that every bank is precharged and no transfer is in flight. The sequencer acts only in that condition. While it owns the command bus it raises `seq_busy`, and the arbiter must issue nothing. `seq_busy` stays high until the recovery interval that follows each command has run out. `ref_urgent` tells the arbiter that the backlog is full and that it should drain traffic so a refresh can go out.

Top module: `rps_sequencer`

## Requirements
- R1: While reset is held and just after it, `cke` is 1, the command lines carry NOP, and `seq_busy` and `ref_urgent` are 0. NOP means cs_n=0, ras_n=1, cas_n=1, we_n=1.
- R2: One refresh becomes owed every REFI_PS/CLK_PS cycles (rounded down), counted from reset. The backlog saturates at MAX_OWED, and `ref_urgent` is 1 exactly while the backlog equals MAX_OWED. An issued refresh lowers it by one.
- R3: An auto-refresh drives cs_n=0, ras_n=0, cas_n=0, we_n=1 with `cke` held at 1 for one cycle. It is issued only from the idle state, only with `all_idle` high and a non-empty backlog, and only when `ref_req` or `ref_urgent` is 1.
- R4: After an auto-refresh, `seq_busy` is high for ceil(TRFC_PS/CLK_PS) cycles, counting the refresh cycle itself. No command is issued during those cycles.
- R5: While `all_idle` is 0, no refresh, self-refresh entry or power-down entry starts, whatever is requested.
- R6: Self-refresh entry drives the refresh encoding in the same cycle that `cke` falls. `cke` then stays 0 with NOP until `wake_req`. While in self-refresh and during its exit wait, the backlog is cleared and the interval count is held.
- R7: On `wake_req` in self-refresh, `cke` rises with NOP. `seq_busy` then stays high, and every request is ignored, for XSR_CYC cycles with `cke` high, counting the rise cycle. After that the sequencer returns to idle.
- R8: Power-down entry drops `cke` with NOP. The sequencer leaves power-down on `wake_req` or on `ref_urgent`, raising `cke` with NOP. It stays busy for PDX_CYC cycles after the rise and may issue its next command one cycle later.
- R9: When several requests are active in idle, refresh wins over self-refresh, and self-refresh wins over power-down.
- R10: `seq_busy` is 1 in every cycle in which `cke` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| all_idle | input | 1 | Arbiter: all banks precharged, bus quiet |
| ref_req | input | 1 | Arbiter offers a slot for a refresh |
| sr_req | input | 1 | Request self-refresh entry |
| pd_req | input | 1 | Request power-down entry |
| wake_req | input | 1 | Request exit from a low-power state |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| seq_busy | output | 1 | Sequencer owns the command bus |
| ref_urgent | output | 1 | Refresh backlog at its limit |

## Verification
The backlog is first filled with no idle window, so the time until `ref_urgent` rises checks the interval length. A long refresh window is then opened across an interval tick while the backlog is full: exactly five refreshes must appear, which tells a saturating backlog from one that keeps counting. Self-refresh is tested with its request still held during the exit wait, which separates an ignored request from an accepted one. The cycle at which power-down ends on its own shows that the backlog was cleared and the count held during self-refresh. Finally, all three requests are raised together to fix the priority order.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RFC,
    ST_SR,
    ST_SRX,
    ST_PD,
    ST_PDX
  } rps_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } rps_cmd_t;

  localparam rps_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam rps_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rps_interval.sv
// Refresh interval counter and saturating backlog of owed refreshes.
module rps_interval #(
  parameter int REFI_CYC = 780,
  parameter int MAX_OWED = 8,
  localparam int CW = $clog2(REFI_CYC),
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          take,
  output logic [OW-1:0] owed,
  output logic          full
);

  localparam logic [CW-1:0] CNT_LAST = CW'(REFI_CYC - 1);
  localparam logic [OW-1:0] OWED_TOP = OW'(MAX_OWED);

  logic [CW-1:0] cnt;
  logic          tick;
  logic [OW-1:0] owed_nx;

  assign tick = (cnt == CNT_LAST);

  always_comb begin
    owed_nx = owed;
    if (tick && !take && owed != OWED_TOP) owed_nx = owed + 1'b1;
    else if (take && !tick)                owed_nx = owed - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      cnt  <= '0;
      owed <= '0;
      full <= 1'b0;
    end else begin
      cnt  <= tick ? '0 : cnt + 1'b1;
      owed <= owed_nx;
      full <= (owed_nx == OWED_TOP);
    end
  end

  // R2: backlog never passes its limit
  assert_owed_cap_R2: assert property (@(posedge clk) disable iff (rst)
    owed <= OWED_TOP);

  // R3: a refresh is only taken against a non-empty backlog
  assert_take_owed_R3: assert property (@(posedge clk) disable iff (rst)
    take |-> owed != '0);

endmodule

// File: rtl/rps_timer.sv
// Down-counter for recovery windows; done while the count is zero.
module rps_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/rps_sequencer.sv
module rps_sequencer
  import rps_pkg::*;
#(
  parameter int CLK_PS   = 10000,
  parameter int REFI_PS  = 7800000,
  parameter int TRFC_PS  = 75000,
  parameter int XSR_CYC  = 200,
  parameter int PDX_CYC  = 2,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic all_idle,
  input  logic ref_req,
  input  logic sr_req,
  input  logic pd_req,
  input  logic wake_req,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic seq_busy,
  output logic ref_urgent
);

  localparam int REFI_CYC = REFI_PS / CLK_PS;
  localparam int TRFC_CYC = cdiv(TRFC_PS, CLK_PS);
  localparam int TMAX_A   = (XSR_CYC > TRFC_CYC) ? XSR_CYC : TRFC_CYC;
  localparam int TMAX     = (TMAX_A > PDX_CYC) ? TMAX_A : PDX_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int OW       = $clog2(MAX_OWED + 1);
  localparam int HW       = $clog2(XSR_CYC + 1);
  localparam int GW       = $clog2(TRFC_CYC + 1);

  rps_state_e    state_q, state_d;
  rps_cmd_t      cmd_q, cmd_d;
  logic          cke_d;
  logic [OW-1:0] owed;
  logic          full, hold;
  logic          do_ref, do_sr, do_pd;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;

  assign hold   = (state_q == ST_SR) || (state_q == ST_SRX);
  assign do_ref = (state_q == ST_IDLE) && all_idle && (owed != '0) && (ref_req || full);
  assign do_sr  = (state_q == ST_IDLE) && all_idle && sr_req && !do_ref;
  assign do_pd  = (state_q == ST_IDLE) && all_idle && pd_req && !do_ref && !sr_req;

  rps_interval #(.REFI_CYC(REFI_CYC), .MAX_OWED(MAX_OWED)) u_interval (
    .clk(clk), .rst(rst), .hold(hold), .take(do_ref), .owed(owed), .full(full)
  );

  rps_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
  );

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    cke_d   = cke;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (do_ref) begin
          state_d = ST_RFC;
          cmd_d   = CMD_REF;
          t_load  = 1'b1;
          t_val   = TW'(TRFC_CYC - 1);
        end else if (do_sr) begin
          state_d = ST_SR;
          cmd_d   = CMD_REF;
          cke_d   = 1'b0;
        end else if (do_pd) begin
          state_d = ST_PD;
          cke_d   = 1'b0;
        end
      end
      ST_RFC:  if (t_done) state_d = ST_IDLE;
      ST_SR: begin
        if (wake_req) begin
          state_d = ST_SRX;
          cke_d   = 1'b1;
          t_load  = 1'b1;
          t_val   = TW'(XSR_CYC - 1);
        end
      end
      ST_SRX:  if (t_done) state_d = ST_IDLE;
      ST_PD: begin
        if (wake_req || full) begin
          state_d = ST_PDX;
          cke_d   = 1'b1;
          t_load  = 1'b1;
          t_val   = TW'(PDX_CYC - 1);
        end
      end
      ST_PDX:  if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_NOP;
      cke      <= 1'b1;
      seq_busy <= 1'b0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      cke      <= cke_d;
      seq_busy <= (state_d != ST_IDLE);
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ref_urgent = full;

  // Checking state observed on the outputs
  logic          prev_cke, sr_flag;
  logic [HW-1:0] hi_cnt;
  logic [GW-1:0] since_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cke  <= 1'b1;
      sr_flag   <= 1'b0;
      hi_cnt    <= '0;
      since_ref <= GW'(TRFC_CYC);
    end else begin
      prev_cke <= cke;
      if (!cke)                           hi_cnt <= '0;
      else if (hi_cnt != HW'(XSR_CYC))    hi_cnt <= hi_cnt + 1'b1;
      if (!cke && cmd_q == CMD_REF)       sr_flag <= 1'b1;
      else if (!cke && prev_cke)          sr_flag <= 1'b0;
      if (cmd_q == CMD_REF && cke)        since_ref <= '0;
      else if (since_ref != GW'(TRFC_CYC)) since_ref <= since_ref + 1'b1;
    end
  end

  assert_ref_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_REF && cke) |-> since_ref >= GW'(TRFC_CYC - 1));

  assert_idle_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP || $fell(cke)) |-> $past(all_idle));

  assert_sr_exit_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP && sr_flag) |-> hi_cnt >= HW'(XSR_CYC));

  assert_wake_nop_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> cmd_q == CMD_NOP);

  assert_busy_lowpwr_R10: assert property (@(posedge clk) disable iff (rst)
    !cke |-> seq_busy);

endmodule

// File: tb/rps_sequencer_bench.sv
module rps_sequencer_bench;

  localparam logic [5:0] EV_REF   = 6'b11_0001;
  localparam logic [5:0] EV_SR_IN = 6'b10_0001;
  localparam logic [5:0] EV_PD_IN = 6'b10_0111;
  localparam logic [5:0] EV_WAKE  = 6'b01_0111;

  logic clk = 1'b0;
  logic rst, all_idle, ref_req, sr_req, pd_req, wake_req;
  logic cke, cs_n, ras_n, cas_n, we_n, seq_busy, ref_urgent;

  always #5 clk = ~clk;

  rps_sequencer #(
    .CLK_PS(10000), .REFI_PS(400000), .TRFC_PS(75000),
    .XSR_CYC(200), .PDX_CYC(2), .MAX_OWED(4)
  ) u_rps_sequencer (
    .clk(clk), .rst(rst), .all_idle(all_idle), .ref_req(ref_req),
    .sr_req(sr_req), .pd_req(pd_req), .wake_req(wake_req),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .seq_busy(seq_busy), .ref_urgent(ref_urgent)
  );

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  bit ended = 1'b0;
  logic [5:0] exp_q[$];
  logic mon_prev = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    t++;
  endtask

  task automatic wait_until(input int x);
    while (t < x) step();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: every bus event (command other than NOP, or cke change) is popped and compared
  always @(negedge clk) begin
    logic [5:0] ev;
    logic [5:0] e;
    ev = {mon_prev, cke, cs_n, ras_n, cas_n, we_n};
    if (!rst && (cke != mon_prev || {cs_n, ras_n, cas_n, we_n} != 4'b0111)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected bus event", int'(ev), 0);
      end else begin
        e = exp_q.pop_front();
        chk(ev == e, "R3/R6/R8 bus event", int'(ev), int'(e));
      end
    end
    mon_prev = cke;
  end

  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "watchdog expired", t, 0);
    finish_run();
  end

  initial begin
    int n;
    int base;
    int rise_t;
    rst = 1'b1; all_idle = 1'b0; ref_req = 1'b0; sr_req = 1'b0; pd_req = 1'b0; wake_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(cke == 1'b1, "R1 cke after reset", int'(cke), 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP after reset", int'({cs_n, ras_n, cas_n, we_n}), 7);
    chk(seq_busy == 1'b0, "R1 busy after reset", int'(seq_busy), 0);
    chk(ref_urgent == 1'b0, "R1 urgent after reset", int'(ref_urgent), 0);
    rst = 1'b0;
    t = 0;

    // R2: backlog fills to 4 after 4 intervals of 40 cycles
    while (!ref_urgent && t < 400) step();
    chk(t == 160, "R2 urgent at backlog limit", t, 160);

    // R2 saturation: tick at 200 is lost, so exactly five refreshes (one from the tick at 240)
    wait_until(205);
    all_idle = 1'b1; ref_req = 1'b1;
    repeat (5) exp_q.push_back(EV_REF);
    step();
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0001 && cke, "R3 refresh encoding", int'({cke, cs_n, ras_n, cas_n, we_n}), 17);
    chk(ref_urgent == 1'b0, "R2 urgent drops after refresh", int'(ref_urgent), 0);
    n = 0;
    while (seq_busy && n < 50) begin n++; step(); end
    chk(n == 8, "R4 busy length after refresh", n, 8);

    // R5: requests with banks not idle do nothing
    wait_until(270);
    ref_req = 1'b0; all_idle = 1'b0; sr_req = 1'b1; pd_req = 1'b1;
    wait_until(290);
    chk(cke == 1'b1 && !seq_busy, "R5 no action without all_idle", int'({cke, seq_busy}), 2);

    // R6/R9: self-refresh chosen over power-down
    all_idle = 1'b1;
    exp_q.push_back(EV_SR_IN);
    step();
    chk(cke == 1'b0, "R9 self-refresh before power-down", int'(cke), 0);
    chk(seq_busy == 1'b1, "R10 busy in low power", int'(seq_busy), 1);
    pd_req = 1'b0;
    wait_until(321);
    chk(cke == 1'b0, "R6 cke held low", int'(cke), 0);

    // R7: exit wait with sr_req still held
    wake_req = 1'b1;
    exp_q.push_back(EV_WAKE);
    exp_q.push_back(EV_SR_IN);
    step();
    wake_req = 1'b0;
    n = 0;
    while (seq_busy && cke && n < 400) begin n++; step(); end
    chk(n == 200, "R7 exit wait length", n, 200);
    step();
    chk(cke == 1'b0, "R7 request accepted after wait", int'(cke), 0);

    wait_until(530);
    sr_req = 1'b0; all_idle = 1'b0; wake_req = 1'b1;
    exp_q.push_back(EV_WAKE);
    step();
    wake_req = 1'b0;
    while (seq_busy && t < 1000) step();
    base = t;

    // R8 urgent exit; time shows R6 cleared backlog and held count
    all_idle = 1'b1; pd_req = 1'b1;
    exp_q.push_back(EV_PD_IN);
    exp_q.push_back(EV_WAKE);
    exp_q.push_back(EV_REF);
    step();
    pd_req = 1'b0;
    chk(cke == 1'b0, "R8 power-down entry", int'(cke), 0);
    while (!cke && t < 1500) step();
    chk(t - base == 161, "R6 backlog restart and R8 urgent wake", t - base, 161);
    rise_t = t;
    while ({cs_n, ras_n, cas_n, we_n} != 4'b0001 && t < rise_t + 20) step();
    chk(t - rise_t == 3, "R8 first command after power-down exit", t - rise_t, 3);

    // R8 wake exit
    wait_until(905);
    pd_req = 1'b1;
    exp_q.push_back(EV_PD_IN);
    step();
    pd_req = 1'b0;
    chk(cke == 1'b0, "R8 power-down entry again", int'(cke), 0);
    wait_until(915);
    wake_req = 1'b1;
    exp_q.push_back(EV_WAKE);
    step();
    wake_req = 1'b0;
    chk(cke == 1'b1, "R8 wake raises cke", int'(cke), 1);
    wait_until(920);
    all_idle = 1'b0;

    // R9: refresh beats both low-power requests
    wait_until(925);
    all_idle = 1'b1; ref_req = 1'b1; sr_req = 1'b1; pd_req = 1'b1;
    exp_q.push_back(EV_REF);
    exp_q.push_back(EV_SR_IN);
    step();
    chk({cke, cs_n, ras_n, cas_n, we_n} == 5'b10001, "R9 refresh first", int'({cke, cs_n, ras_n, cas_n, we_n}), 17);
    ref_req = 1'b0;
    wait_until(935);
    chk(cke == 1'b0, "R9 self-refresh second", int'(cke), 0);

    wait_until(940);
    sr_req = 1'b0; pd_req = 1'b0; all_idle = 1'b0; wake_req = 1'b1;
    exp_q.push_back(EV_WAKE);
    step();
    wake_req = 1'b0;
    while (seq_busy && t < 1400) step();
    repeat (5) step();
    chk(exp_q.size() == 0, "R3/R6/R8 all expected events seen", exp_q.size(), 0);
    finish_run();
  end

endmodule